// File: doc/BRIEF.md
# Serial Prefix-Code Opcode Decoder

This block turns a stream of single bits into 3-bit opcodes. The opcodes arrive as codewords of unequal length, 2 to 4 bits. No codeword is the start of another. A producer sends one bit per clock, with the first bit of each codeword first, and marks each bit with a valid strobe. The decoder tracks its position in the code tree. When the last bit of a codeword arrives, it raises a one-cycle completion pulse, shows the fixed opcode and the number of bits the codeword used, and moves back to the root of the tree.

A codeword is complete as soon as its last bit arrives, because the code is prefix-free. The decoder needs no lookahead and no idle cycle between codewords. A synchronous reset or an abort input discards a partly received codeword. When the encoder view is enabled by parameter, it shows the codeword for any opcode placed on a separate input, combinationally.

Top module: `pfx_opcode_decoder`

## Requirements
- R1: After a synchronous reset, `done` is 0, `opcode` is 0 and `code_len` is 0, and the walk starts from the root.
- R2: The 2-bit codewords decode as follows, with the first received bit written leftmost: 00 gives opcode 000 and 01 gives opcode 001. Both report `code_len` = 2.
- R3: The 3-bit codewords decode as follows: 100 gives opcode 010 and 101 gives opcode 011. Both report `code_len` = 3.
- R4: The 4-bit codewords decode as follows: 1100 gives 100, 1101 gives 101, 1110 gives 110 and 1111 gives 111. All report `code_len` = 4.
- R5: `done` is high for exactly the one cycle after the clock edge that accepts the final bit of a codeword. `opcode` and `code_len` keep their values until the next completion.
- R6: A valid bit presented in the cycle in which `done` is high is the first bit of the next codeword, so codewords sent back to back decode with no gap cycle.
- R7: While `bit_vld` is low, the walk holds its position. Idle cycles inside a codeword do not change the decoded result and do not raise `done`.
- R8: `abort` returns the walk to the root and discards any partial codeword. A bit presented in the same cycle as `abort` is discarded.
- R9: A reset that arrives in the middle of a codeword discards the partial codeword. The next codeword then decodes from the root.
- R10: With the encoder view enabled, `enc_code` shows the codeword for `enc_op`, right-aligned so that the first transmitted bit is at position `enc_len`-1. `enc_len` shows its length (2, 3 or 4).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| abort | input | 1 | Discards any partial codeword and returns the walk to the root |
| bit_vld | input | 1 | Qualifies `bit_in` |
| bit_in | input | 1 | Next codeword bit, first bit of the codeword first |
| done | output | 1 | One-cycle pulse when a codeword completes |
| opcode | output | 3 | Decoded fixed opcode |
| code_len | output | 3 | Length of the completed codeword |
| enc_op | input | 3 | Opcode shown in the encoder view |
| enc_code | output | 4 | Right-aligned codeword for `enc_op` |
| enc_len | output | 3 | Length of the codeword for `enc_op` |

## Verification
The in-line assertions check the following on every cycle:
- `done` never stays high for two cycles.
- The walk holds while no bit is valid.
- An abort always lands at the root.
- A reported length is always 2 to 4.
- A tree position at depth 3 always lies under the 11 branch.
- The encoder view always reports a length that matches the opcode class.

Only the bench scenarios can show the following:
- Each of the eight codewords maps to the correct opcode.
- Back-to-back codewords separate at the right bit.
- Idle gaps inside a codeword leave the result unchanged.
- An abort or a reset in the middle of a codeword changes which opcode the following bits produce.

// File: rtl/pfx_pkg.sv
package pfx_pkg;
  localparam int OP_W   = 3;
  localparam int CW_MAX = 4;
  localparam int LEN_W  = $clog2(CW_MAX + 1);
  localparam int DEP_W  = $clog2(CW_MAX);
  localparam int PATH_W = CW_MAX - 1;

  typedef logic [OP_W-1:0]   op_t;
  typedef logic [LEN_W-1:0]  len_t;
  typedef logic [CW_MAX-1:0] cw_t;

  typedef struct packed {
    logic hit;
    op_t  op;
    len_t len;
  } step_t;

  // One step of the tree walk. path holds the bits already taken
  // (the most recent bit in path[0]), depth is how many there are,
  // and b is the bit arriving now.
  function automatic step_t tree_step(logic [PATH_W-1:0] path,
                                      logic [DEP_W-1:0] depth, logic b);
    step_t s;
    s = '0;
    case (depth)
      2'd1: if (path[0] == 1'b0) begin
        s.hit = 1'b1; s.op = {2'b00, b}; s.len = len_t'(2);
      end
      2'd2: if (path[1:0] == 2'b10) begin
        s.hit = 1'b1; s.op = {2'b01, b}; s.len = len_t'(3);
      end
      2'd3: if (path[2:1] == 2'b11) begin
        s.hit = 1'b1; s.op = {1'b1, path[0], b}; s.len = len_t'(4);
      end
      default: s = '0;
    endcase
    return s;
  endfunction

  function automatic len_t op_len(op_t op);
    if (op[2])      return len_t'(4);
    else if (op[1]) return len_t'(3);
    else            return len_t'(2);
  endfunction

  function automatic cw_t op_code(op_t op);
    if (op[2])      return {2'b11, op[1], op[0]};
    else if (op[1]) return {1'b0, 2'b10, op[0]};
    else            return {2'b00, 1'b0, op[0]};
  endfunction
endpackage

// File: rtl/pfx_walker.sv
module pfx_walker
  import pfx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              abort,
  input  logic              bit_vld,
  input  logic              bit_in,
  output logic              hit_w,
  output op_t               hit_op,
  output len_t              hit_len,
  output logic [DEP_W-1:0]  depth,
  output logic [PATH_W-1:0] path
);
  step_t            step_w;
  logic             take_w;
  logic             root_w;

  assign take_w  = bit_vld && !abort;
  assign step_w  = tree_step(path, depth, bit_in);
  assign hit_w   = take_w && step_w.hit;
  assign hit_op  = step_w.op;
  assign hit_len = step_w.len;
  assign root_w  = (depth == '0);

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      depth <= '0;
      path  <= '0;
    end else if (take_w) begin
      if (step_w.hit) begin
        depth <= '0;
        path  <= '0;
      end else begin
        depth <= depth + 1'b1;
        path  <= {path[PATH_W-2:0], bit_in};
      end
    end
  end

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!bit_vld && !abort) |=> ($stable(depth) && $stable(path))); // R7
  AST_ABORT_ROOT: assert property (@(posedge clk) disable iff (rst)
    abort |=> root_w); // R8
  AST_DEEP_BRANCH: assert property (@(posedge clk) disable iff (rst)
    (depth == 2'd3) |-> (path[2:1] == 2'b11)); // R4
endmodule

// File: rtl/pfx_result_reg.sv
module pfx_result_reg
  import pfx_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic hit_w,
  input  op_t  hit_op,
  input  len_t hit_len,
  output logic done,
  output op_t  opcode,
  output len_t code_len
);
  always_ff @(posedge clk) begin
    if (rst) begin
      done     <= 1'b0;
      opcode   <= '0;
      code_len <= '0;
    end else begin
      done <= hit_w;
      if (hit_w) begin
        opcode   <= hit_op;
        code_len <= hit_len;
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R5
  AST_LEN_RANGE: assert property (@(posedge clk) disable iff (rst)
    done |-> (code_len >= len_t'(2) && code_len <= len_t'(4))); // R5
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
    !hit_w |=> ($stable(opcode) && $stable(code_len))); // R5
endmodule

// File: rtl/pfx_encoder.sv
module pfx_encoder
  import pfx_pkg::*;
(
  input  op_t  enc_op,
  output cw_t  enc_code,
  output len_t enc_len
);
  assign enc_code = op_code(enc_op);
  assign enc_len  = op_len(enc_op);

  always_comb begin
    AST_ENC_LEN_CLASS: assert (enc_op[2] ? (enc_len == len_t'(4))
      : (enc_len == (enc_op[1] ? len_t'(3) : len_t'(2)))); // R10
  end
endmodule

// File: rtl/pfx_opcode_decoder.sv
module pfx_opcode_decoder
  import pfx_pkg::*;
#(
  parameter bit ENC_EN = 1'b1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       abort,
  input  logic       bit_vld,
  input  logic       bit_in,
  output logic       done,
  output logic [2:0] opcode,
  output logic [2:0] code_len,
  input  logic [2:0] enc_op,
  output logic [3:0] enc_code,
  output logic [2:0] enc_len
);
  logic              hit_w;
  op_t               hit_op;
  len_t              hit_len;
  logic [DEP_W-1:0]  depth;
  logic [PATH_W-1:0] path;

  pfx_walker u_walk (
    .clk(clk), .rst(rst), .abort(abort), .bit_vld(bit_vld), .bit_in(bit_in),
    .hit_w(hit_w), .hit_op(hit_op), .hit_len(hit_len),
    .depth(depth), .path(path)
  );

  pfx_result_reg u_res (
    .clk(clk), .rst(rst), .hit_w(hit_w), .hit_op(hit_op), .hit_len(hit_len),
    .done(done), .opcode(opcode), .code_len(code_len)
  );

  generate
    if (ENC_EN) begin : g_enc
      pfx_encoder u_enc (.enc_op(enc_op), .enc_code(enc_code), .enc_len(enc_len));
    end else begin : g_noenc
      assign enc_code = '0;
      assign enc_len  = '0;
    end
  endgenerate

  AST_RESET_ROOT: assert property (@(posedge clk)
    rst |=> (depth == '0 && !done)); // R9
endmodule

// File: tb/sim_pfx_opcode_decoder.sv
module sim_pfx_opcode_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 20000;

  logic clk = 1'b0;
  logic rst, abort, bit_vld, bit_in;
  logic done;
  logic [2:0] opcode, code_len, enc_op, enc_len;
  logic [3:0] enc_code;
  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pfx_opcode_decoder u0 (
    .clk(clk), .rst(rst), .abort(abort), .bit_vld(bit_vld), .bit_in(bit_in),
    .done(done), .opcode(opcode), .code_len(code_len),
    .enc_op(enc_op), .enc_code(enc_code), .enc_len(enc_len)
  );

  // Expected code table, first transmitted bit at index len-1.
  function automatic logic [3:0] exp_code(input logic [2:0] op);
    case (op)
      3'd0: return 4'b0000; 3'd1: return 4'b0001;
      3'd2: return 4'b0100; 3'd3: return 4'b0101;
      3'd4: return 4'b1100; 3'd5: return 4'b1101;
      3'd6: return 4'b1110; default: return 4'b1111;
    endcase
  endfunction
  function automatic int exp_len(input logic [2:0] op);
    return (op < 3'd2) ? 2 : (op < 3'd4) ? 3 : 4;
  endfunction
  function automatic string req_of(input logic [2:0] op);
    return (op < 3'd2) ? "R2" : (op < 3'd4) ? "R3" : "R4";
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic put(input logic v, input logic b);
    @(negedge clk); bit_vld = v; bit_in = b;
  endtask

  task automatic idle_check_done(input string req, input logic [2:0] op, input int len);
    @(negedge clk); bit_vld = 1'b0; abort = 1'b0;
    chk(req, done, 1); chk(req, opcode, op); chk(req, code_len, len);
  endtask

  task automatic send_op(input logic [2:0] op);
    for (int i = exp_len(op) - 1; i >= 0; i--) put(1'b1, exp_code(op)[i]);
  endtask

  task automatic t_reset;
    rst = 1'b1; abort = 1'b0; bit_vld = 1'b0; bit_in = 1'b0; enc_op = 3'd0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 done", done, 0); chk("R1 opcode", opcode, 0); chk("R1 len", code_len, 0);
  endtask

  task automatic t_each_code;
    for (int k = 0; k < 8; k++) begin
      send_op(3'(k));
      idle_check_done(req_of(3'(k)), 3'(k), exp_len(3'(k)));
      @(negedge clk);
      chk("R5 pulse", done, 0); chk("R5 held op", opcode, k);
      chk("R5 held len", code_len, exp_len(3'(k)));
    end
  endtask

  task automatic t_back_to_back;
    logic [2:0] seq [6];
    logic pend;
    logic [2:0] pop;
    seq = '{3'd0, 3'd7, 3'd2, 3'd1, 3'd5, 3'd0};
    pend = 1'b0; pop = '0;
    for (int w = 0; w < 6; w++) begin
      for (int i = exp_len(seq[w]) - 1; i >= 0; i--) begin
        @(negedge clk);
        chk("R6 done", done, pend);
        if (pend) chk("R6 op", opcode, pop);
        bit_vld = 1'b1; bit_in = exp_code(seq[w])[i];
        pend = (i == 0); pop = seq[w];
      end
    end
    idle_check_done("R6 last", 3'd0, 2);
  endtask

  task automatic t_gaps;
    put(1'b1, 1'b1); put(1'b0, 1'b0); put(1'b0, 1'b1);
    chk("R7 no done in gap", done, 0);
    put(1'b1, 1'b1); put(1'b0, 1'b0);
    chk("R7 no done in gap", done, 0);
    put(1'b1, 1'b0); put(1'b0, 1'b1); put(1'b1, 1'b1);
    idle_check_done("R7 gapped SUB", 3'd5, 4);
  endtask

  task automatic t_abort;
    put(1'b1, 1'b1); put(1'b1, 1'b1);
    @(negedge clk); bit_vld = 1'b0; abort = 1'b1;
    @(negedge clk); abort = 1'b0;
    chk("R8 no done on abort", done, 0);
    put(1'b1, 1'b0); put(1'b1, 1'b1);
    idle_check_done("R8 after abort", 3'd1, 2);
    put(1'b1, 1'b1);
    @(negedge clk); bit_vld = 1'b1; bit_in = 1'b1; abort = 1'b1;
    @(negedge clk); abort = 1'b0; bit_in = 1'b0;
    put(1'b1, 1'b0);
    idle_check_done("R8 bit dropped with abort", 3'd0, 2);
  endtask

  task automatic t_reset_mid;
    put(1'b1, 1'b1); put(1'b1, 1'b1); put(1'b1, 1'b1);
    @(negedge clk); bit_vld = 1'b0; rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R9 done cleared", done, 0); chk("R9 op cleared", opcode, 0);
    put(1'b1, 1'b0); put(1'b1, 1'b1);
    idle_check_done("R9 after reset", 3'd1, 2);
  endtask

  task automatic t_encoder;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk); enc_op = 3'(k);
      #1;
      chk("R10 code", enc_code, exp_code(3'(k)));
      chk("R10 len", enc_len, exp_len(3'(k)));
    end
  endtask

  initial begin
    t_reset();
    t_each_code();
    t_back_to_back();
    t_gaps();
    t_abort();
    t_reset_mid();
    t_encoder();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule